// File: doc/BRIEF.md
# Instruction Cycle and Flush Sequencer

This block is the timing front end of a small core with 16-bit program words. It splits the oscillator into instruction cycles of four phases and fetches one program word per cycle. It hands each instruction to the execute stage with a single-clock execute strobe. While the execute stage works on one instruction, the sequencer is already fetching the word that follows it. When the execute stage reports a skip or a jump, the fetched word is thrown away and the next cycle is a dead cycle with no strobe.

Three first-word patterns mark an instruction that spans two words. The sequencer holds such a word for one cycle and then presents both words together with one strobe. A word whose upper four bits are all ones is the tail of a two-word instruction. If such a word arrives without a held first word, it spends one cycle and does nothing. As a result, an instruction costs one, two or three cycles.

Top module: `icyc_sequencer`

## Requirements
- R1: `phaseOh` is one-hot. Starting from bit 0, it steps one bit per clock and returns to bit 0 after bit 3, so each instruction cycle lasts exactly four clocks.
- R2: `fetchAddr` stays constant during a cycle. It changes only on the clock edge that ends phase 3, and then goes up by one, except when a jump is taken.
- R3: `execValid` is high for exactly one clock, in phase 0 of the cycle that executes an instruction. After reset is released, the first strobe comes on the fourth clock, one cycle after the fetch from address 0.
- R4: Consecutive single-word instructions with no skip and no jump give strobes four clocks apart. Each strobe presents the word on `execWord1`, with `execDouble` low and `execWord2` zero.
- R5: A word is a two-word first word when it matches one of three patterns: bits 15:9 equal 1110110, or bits 15:8 equal 0xEF, or bits 15:12 equal 0xC. Such a word raises no strobe in its own cycle. The next cycle strobes with the first word on `execWord1`, the following word on `execWord2` and `execDouble` high, eight clocks after the previous strobe.
- R6: A word with bits 15:12 equal to 0xF that arrives without a held first word uses one cycle and raises no strobe. Skip or jump inputs during that cycle have no effect.
- R7: `exTaken` and `exJump` are sampled on the last clock of a cycle that executed an instruction. The next cycle is flushed and gives no strobe. On a skip, the prefetched word is discarded and fetching continues in sequence. On a jump, `fetchAddr` takes `exTarget`.
- R8: A two-word instruction that takes a jump occupies three cycles. Twelve clocks pass between the end of the cycle of the instruction before it and the strobe of the instruction at the target.
- R9: `exTaken` and `exJump` are ignored in any cycle without an execute strobe: a hold cycle, a flushed cycle, or a lone-tail cycle.
- R10: A synchronous reset sets `fetchAddr` to 0 and `phaseOh` to 0001, drops any prefetched or held word, and keeps `execValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| progData | input | 16 | Program word read at `fetchAddr` |
| exTaken | input | 1 | Execute stage: condition true, skip the next word |
| exJump | input | 1 | Execute stage: program counter reload |
| exTarget | input | PC_W | Jump target word address |
| fetchAddr | output | PC_W | Program word address being fetched |
| phaseOh | output | 4 | One-hot phase of the instruction cycle |
| execValid | output | 1 | Execute strobe, one clock per instruction |
| execDouble | output | 1 | Strobed instruction has two words |
| execWord1 | output | 16 | First (or only) instruction word |
| execWord2 | output | 16 | Second word, zero for single-word instructions |

## Verification
A word fetched in cycle N reaches the execute strobe on the first clock of cycle N+1, or of cycle N+2 if it is a held first word. A skip or jump sampled on the fourth clock of a cycle takes effect at the very next edge, on `fetchAddr` and on a strobe-free phase 0. The reference model advances with the same edge count, so every output is compared on the falling edge that follows the edge where it was due. A table of strobe times then confirms the 4-, 8- and 12-clock spans between named instructions.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
  localparam int WORD_W  = 16;
  localparam int PHASES  = 4;
  localparam int NUM_DBL = 3;

  // mask/match pairs identifying the first word of a two-word instruction
  localparam logic [NUM_DBL-1:0][WORD_W-1:0] DBL_MASK  = {16'hF000, 16'hFF00, 16'hFE00};
  localparam logic [NUM_DBL-1:0][WORD_W-1:0] DBL_MATCH = {16'hC000, 16'hEF00, 16'hEC00};
  localparam logic [3:0] TAIL_TAG = 4'hF;

  typedef struct packed {
    logic loadBuf;
    logic loadHold;
    logic pcInc;
    logic pcLoad;
  } seqStrobes_t;

  typedef struct packed {
    logic isFirst;
    logic isTail;
  } wordClass_t;
endpackage

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wordClass_t        cls,
  input  logic              exTaken,
  input  logic              exJump,
  output seqStrobes_t       stb,
  output logic [PHASES-1:0] phaseOh,
  output logic              execValid,
  output logic              cycExec,
  output logic              execPair
);
  localparam int PH_W = $clog2(PHASES);

  logic [PH_W-1:0] phase;
  logic bufValid, holdValid;
  logic lastPhase, execSingle, startHold, flushReq;

  assign lastPhase  = (phase == PH_W'(PHASES - 1));
  assign execPair   = bufValid && holdValid;
  assign execSingle = bufValid && !holdValid && !cls.isFirst && !cls.isTail;
  assign cycExec    = execPair || execSingle;
  assign startHold  = bufValid && !holdValid && cls.isFirst;
  assign flushReq   = lastPhase && cycExec && (exTaken || exJump);

  always_comb begin
    stb.loadBuf  = lastPhase && !flushReq;
    stb.loadHold = lastPhase && startHold;
    stb.pcLoad   = flushReq && exJump;
    stb.pcInc    = lastPhase && !(flushReq && exJump);
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    assign phaseOh[i] = (phase == PH_W'(i));
  end

  assign execValid = phaseOh[0] && cycExec;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      bufValid  <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      phase <= lastPhase ? '0 : phase + 1'b1;
      if (lastPhase) begin
        bufValid  <= !flushReq;
        holdValid <= startHold;
      end
    end
  end
endmodule

// File: rtl/icyc_datapath.sv
module icyc_datapath
  import icyc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       stb,
  input  logic              execPair,
  input  logic [WORD_W-1:0] progData,
  input  logic [PC_W-1:0]   exTarget,
  output logic [PC_W-1:0]   fetchAddr,
  output wordClass_t        cls,
  output logic [WORD_W-1:0] execWord1,
  output logic [WORD_W-1:0] execWord2
);
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] bufWord, heldWord;
  logic [NUM_DBL-1:0] hit;

  for (genvar g = 0; g < NUM_DBL; g++) begin : g_match
    assign hit[g] = ((bufWord & DBL_MASK[g]) == DBL_MATCH[g]);
  end

  assign cls.isFirst = |hit;
  assign cls.isTail  = (bufWord[WORD_W-1 -: 4] == TAIL_TAG);

  assign fetchAddr = pc;
  assign execWord1 = execPair ? heldWord : bufWord;
  assign execWord2 = execPair ? bufWord : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      bufWord  <= '0;
      heldWord <= '0;
    end else begin
      if (stb.pcLoad)       pc <= exTarget;
      else if (stb.pcInc)   pc <= pc + 1'b1;
      if (stb.loadBuf)  bufWord  <= progData;
      if (stb.loadHold) heldWord <= bufWord;
    end
  end
endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
  import icyc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     progData,
  input  logic            exTaken,
  input  logic            exJump,
  input  logic [PC_W-1:0] exTarget,
  output logic [PC_W-1:0] fetchAddr,
  output logic [3:0]      phaseOh,
  output logic            execValid,
  output logic            execDouble,
  output logic [15:0]     execWord1,
  output logic [15:0]     execWord2
);
  seqStrobes_t stb;
  wordClass_t  cls;
  logic cycExec, execPair;

  icyc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cls(cls), .exTaken(exTaken), .exJump(exJump),
    .stb(stb), .phaseOh(phaseOh), .execValid(execValid),
    .cycExec(cycExec), .execPair(execPair)
  );

  icyc_datapath #(.PC_W(PC_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .execPair(execPair),
    .progData(progData), .exTarget(exTarget), .fetchAddr(fetchAddr),
    .cls(cls), .execWord1(execWord1), .execWord2(execWord2)
  );

  assign execDouble = execPair;
endmodule

// File: rtl/icyc_checker.sv
module icyc_checker #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      phaseOh,
  input logic [PC_W-1:0] fetchAddr,
  input logic            execValid,
  input logic            cycExec,
  input logic            exTaken,
  input logic            exJump,
  input logic [PC_W-1:0] exTarget
);
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot(phaseOh)); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst) phaseOh[3] |=> phaseOh[0]); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) !phaseOh[3] |=> $stable(fetchAddr)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    phaseOh[3] && !(cycExec && exJump) |=> fetchAddr == PC_W'($past(fetchAddr) + 1'b1)); // R2
  AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (rst) execValid |-> phaseOh[0]); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    phaseOh[3] && cycExec && exJump |=> fetchAddr == $past(exTarget)); // R7
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    phaseOh[3] && cycExec && (exTaken || exJump) |=> !execValid); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (fetchAddr == '0 && phaseOh == 4'b0001 && !execValid)); // R10
endmodule

bind icyc_sequencer icyc_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .phaseOh(phaseOh), .fetchAddr(fetchAddr),
  .execValid(execValid), .cycExec(cycExec), .exTaken(exTaken),
  .exJump(exJump), .exTarget(exTarget)
);

// File: tb/icyc_sequencer_tb.sv
module icyc_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exTaken = 1'b0, exJump = 1'b0;
  logic [PC_W-1:0] exTarget = '0;
  logic [15:0] progData;
  logic [PC_W-1:0] fetchAddr;
  logic [3:0] phaseOh;
  logic execValid, execDouble;
  logic [15:0] execWord1, execWord2;

  logic [15:0] mem [64];
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign progData = mem[fetchAddr[5:0]];

  icyc_sequencer #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .progData(progData), .exTaken(exTaken),
    .exJump(exJump), .exTarget(exTarget), .fetchAddr(fetchAddr),
    .phaseOh(phaseOh), .execValid(execValid), .execDouble(execDouble),
    .execWord1(execWord1), .execWord2(execWord2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit isFirstW(input logic [15:0] w);
    return (w[15:9] == 7'b1110110) || (w[15:8] == 8'hEF) || (w[15:12] == 4'hC);
  endfunction

  // behavioural reference: queues of fetched and held words
  logic [15:0] pend[$];
  logic [15:0] held[$];
  int mPc = 0, mPhase = 0, t = 0;
  int strobeT[$];
  logic [15:0] strobeW[$];

  function automatic int modelKind();  // 0 none, 1 single, 2 pair
    if (held.size() > 0 && pend.size() > 0) return 2;
    if (pend.size() > 0 && !isFirstW(pend[0]) && pend[0][15:12] != 4'hF) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pend.delete(); held.delete(); mPc = 0; mPhase = 0; t = 0;
    end else begin
      t++;
      if (mPhase == 3) begin
        if (modelKind() != 0 && (exTaken || exJump)) begin
          pend.delete(); held.delete();
          mPc = exJump ? int'(exTarget) : (mPc + 1) % 4096;
        end else begin
          if (modelKind() == 2) begin held.delete(); pend.delete(); end
          else if (pend.size() > 0 && isFirstW(pend[0])) begin held.push_back(pend[0]); pend.delete(); end
          else pend.delete();
          pend.push_back(mem[mPc % 64]);
          mPc = (mPc + 1) % 4096;
        end
      end
      mPhase = (mPhase + 1) % 4;
    end
  end

  // compare away from the edge, then act as the execute stage
  always @(negedge clk) begin
    if (!rst && !done) begin
      int k;
      k = modelKind();
      chk(phaseOh == 4'(1 << mPhase), "R1 phase", phaseOh, 1 << mPhase);
      chk(fetchAddr == PC_W'(mPc), "R2 fetchAddr", fetchAddr, mPc);
      chk(execValid == (mPhase == 0 && k != 0), "R3 execValid", execValid, (mPhase == 0 && k != 0));
      if (mPhase == 0 && k != 0) begin
        logic [15:0] w1, w2;
        w1 = (k == 2) ? held[0] : pend[0];
        w2 = (k == 2) ? pend[0] : 16'h0;
        chk(execWord1 == w1, "R4 execWord1", execWord1, w1);
        chk(execWord2 == w2, "R5 execWord2", execWord2, w2);
        chk(execDouble == (k == 2), "R5 execDouble", execDouble, (k == 2));
      end
      if (execValid) begin strobeT.push_back(t); strobeW.push_back(execWord1); end
      if (mPhase == 0) begin
        if (k == 0) begin
          // R9: noise on the flags in cycles with nothing executing
          exTaken = 1'b1; exJump = 1'b1; exTarget = 12'h7FF;
        end else if (k == 1) begin
          exTaken  = (pend[0][15:8] == 8'hB5) && pend[0][0];
          exJump   = (pend[0][15:12] == 4'hD);
          exTarget = {4'h0, pend[0][7:0]};
        end else begin
          exTaken  = 1'b0;
          exJump   = (held[0][15:8] == 8'hEF);
          exTarget = pend[0][11:0];
        end
      end
    end
  end

  function automatic int tOf(input logic [15:0] w);
    foreach (strobeW[i]) if (strobeW[i] == w) return strobeT[i];
    return -1000;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0BAD;
    mem[0] = 16'h0101;  mem[1] = 16'h0102;
    mem[2] = 16'hEF10;  mem[3] = 16'hF008;   // two-word jump to 8
    mem[8] = 16'h0201;
    mem[9] = 16'hC123;  mem[10] = 16'hF456;  // two-word, no jump
    mem[11] = 16'hF0AA;                      // lone tail
    mem[12] = 16'hB501;                      // skip taken
    mem[13] = 16'hEC20; mem[14] = 16'hF0F0;  // skipped first word, tail runs alone
    mem[15] = 16'hD014;                      // jump to 20
    mem[20] = 16'h0301; mem[21] = 16'hB500;  // skip not taken
    mem[22] = 16'h0302; mem[23] = 16'hD000;  // jump to 0
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fetchAddr == '0 && phaseOh == 4'b0001 && !execValid, "R10 reset state", {fetchAddr, phaseOh}, 16'h0001);
    rst = 1'b0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(strobeT.size() > 0 && strobeT[0] == 4, "R3 first strobe clock", strobeT.size() > 0 ? strobeT[0] : -1, 4);
    chk(tOf(16'h0302) - tOf(16'hB500) == 4, "R4 single gap", tOf(16'h0302) - tOf(16'hB500), 4);
    chk(tOf(16'hB500) - tOf(16'h0301) == 4, "R4 single gap", tOf(16'hB500) - tOf(16'h0301), 4);
    chk(tOf(16'hC123) - tOf(16'h0201) == 8, "R5 two-word gap", tOf(16'hC123) - tOf(16'h0201), 8);
    chk(tOf(16'hB501) - tOf(16'hC123) == 8, "R6 lone tail cycle", tOf(16'hB501) - tOf(16'hC123), 8);
    chk(tOf(16'h0301) - tOf(16'hD014) == 8, "R7 jump flush", tOf(16'h0301) - tOf(16'hD014), 8);
    chk(tOf(16'hD014) - tOf(16'hB501) == 12, "R7 skip of two-word", tOf(16'hD014) - tOf(16'hB501), 12);
    chk(tOf(16'h0201) - tOf(16'h0102) - 4 == 12, "R8 taken two-word span", tOf(16'h0201) - tOf(16'h0102) - 4, 12);
    chk(tOf(16'h0BAD) < 0 && tOf(16'hEC20) < 0, "R7 discarded words", tOf(16'h0BAD), -1000);
    chk(tOf(16'hF0AA) < 0 && tOf(16'hF0F0) < 0, "R9 tail no strobe", tOf(16'hF0AA), -1000);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(fetchAddr == '0 && phaseOh == 4'b0001 && !execValid, "R10 mid-run reset", {fetchAddr, phaseOh}, 16'h0001);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule